// File: doc/BRIEF.md
# Micro-Operation Controlled Nibble ALU

This block is the arithmetic core of a small 4-bit controller. Each instruction is described by a word of micro-operation enable bits. Each enabled bit ORs one source onto one of two adder operands. The result can update the accumulator, the Y register or the status latch, and it can write RAM. A second decode path handles the fixed set-bit and clear-bit instructions. A one-bit flag picks which of the two paths is active. The accumulator, Y, X, the RAM array and the status latch are held outside this block. The block reads their values and returns write strobes and write data.

A free-running four-slot sequencer paces each instruction:

- Slot 0 (latch): the block captures the decode and all data inputs, forces status to 1 and clears the operands and the carry-in.
- Slot 1 (select): the two operands are formed.
- Slot 2 (add): the add and the status update happen, and the RAM write is prepared.
- Slot 3 (store): the RAM write strobe is presented, and the register write-backs are registered.

The register write-back strobes appear during slot 0 of the following instruction. The surrounding logic presents the inputs for an instruction while `phase` reads 0.

Top module: `nib_uop_alu`

## Requirements
- R1: After reset is released, `phase` steps 0,1,2,3 and then wraps to 0, advancing by one every clock.
- R2: While reset is held, `phase` is 0, `status` is 1, and `ram_we`, `acc_we`, `y_we` and `stl_we` are all 0.
- R3: The N operand is the bitwise OR of the enabled sources. The enable bits of `uop` are: bit 0 selects constant 15, bit 1 the accumulator, bit 2 the inverted accumulator, bit 3 the key nibble, bit 4 the RAM nibble. With no N bit set, N is 0.
- R4: The P operand is the bitwise OR of the enabled sources. The enable bits of `uop` are: bit 5 selects Y, bit 6 the DAM nibble, bit 7 the inverted DAM nibble, bit 8 the key nibble, bit 9 the RAM nibble. With no P bit set, P is 0.
- R5: The sum is P + N + carry-in, 5 bits wide, and carry-in is `uop` bit 10. `wb_data` carries the low 4 bits of the sum.
- R6: When `uop` bit 11 (not-equal test) is set and N equals P, status is 0. When `uop` bit 12 (carry test) is set, status equals bit 4 of the sum. The carry test wins when both bits are set. Status is valid from slot 3 until the next slot 0 edge.
- R7: With neither test bit set, status stays 1 for the whole instruction.
- R8: `uop` bit 13 writes the accumulator to RAM and `uop` bit 14 writes the key nibble to RAM. The key nibble wins if both are set. `ram_we` is high only in slot 3. `ram_addr` is {X, Y}, with Y in the low 4 bits.
- R9: When `is_micro` is 0, `set_bit` writes the RAM nibble ORed with the one-hot mask 1<<`bit_sel`. `clr_bit` writes the RAM nibble ANDed with the inverted mask, and clear wins if both are set.
- R10: `uop` bits 15, 16 and 17 raise `acc_we`, `y_we` and `stl_we`, respectively, for one cycle during slot 0 of the next instruction.
- R11: When `is_micro` is 0, the `uop` bits have no effect: no write-back strobe, status 1, `wb_data` 0. When `is_micro` is 1, `set_bit` and `clr_bit` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_micro | input | 1 | 1 selects the micro-op path, 0 selects the fixed-instruction path |
| uop | input | 18 | Micro-operation enable bits |
| set_bit | input | 1 | Fixed decode: set one RAM bit |
| clr_bit | input | 1 | Fixed decode: clear one RAM bit |
| bit_sel | input | 2 | Bit index for set/clear |
| acc_in | input | 4 | Accumulator value |
| y_in | input | 4 | Y register value |
| x_in | input | 2 | X register value |
| ram_rdata | input | 4 | RAM nibble at the current address |
| key_in | input | 4 | Key-input nibble |
| dam_in | input | 4 | DAM nibble |
| phase | output | 2 | Current slot of the instruction |
| ram_addr | output | 6 | RAM address {X, Y} |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 4 | RAM write data |
| wb_data | output | 4 | Low 4 bits of the sum |
| acc_we | output | 1 | Accumulator load strobe |
| y_we | output | 1 | Y load strobe |
| stl_we | output | 1 | Status latch load strobe |
| status | output | 1 | Current status |

## Verification
Directed cases isolate each operand source alone and then in combination. This shows that the operands OR their sources together rather than picking one by priority. Sums that produce carry-out 1 and carry-out 0 distinguish the 5-bit sum from a 4-bit one. Equal and unequal operand pairs, with and without the carry test, establish which status rule wins. Seeded random words, including words with many bits set and words with the inactive path's decode bits also set, are checked against a reference model. These cases expose write collisions, precedence between sources, and leakage between the two paths.

// File: rtl/nib_uop_pkg.sv
package nib_uop_pkg;

  typedef enum logic [1:0] {
    PH_LATCH  = 2'd0,
    PH_SELECT = 2'd1,
    PH_ADD    = 2'd2,
    PH_STORE  = 2'd3
  } phase_e;

  // Bit 0 of n_sel is the LSB of the packed word.
  typedef struct packed {
    logic       ld_stl;
    logic       ld_y;
    logic       ld_acc;
    logic       wr_key;
    logic       wr_acc;
    logic       tst_carry;
    logic       tst_ne;
    logic       cin;
    logic [4:0] p_sel;   // y, dam, ~dam, key, ram
    logic [4:0] n_sel;   // 15, acc, ~acc, key, ram
  } uop_t;

  typedef struct packed {
    logic       micro;
    uop_t       uop;
    logic       set_bit;
    logic       clr_bit;
    logic [1:0] bit_sel;
  } ctl_t;

endpackage

// File: rtl/nib_phase_seq.sv
module nib_phase_seq
  import nib_uop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);
  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_LATCH:  phase_d = PH_SELECT;
      PH_SELECT: phase_d = PH_ADD;
      PH_ADD:    phase_d = PH_STORE;
      default:   phase_d = PH_LATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_LATCH;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R1: one step per clock with wrap
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q == phase_e'(2'($past(phase_q) + 2'd1))));
endmodule

// File: rtl/nib_or_sel.sv
module nib_or_sel #(
  parameter int W    = 4,
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0]   en,
  input  logic [NSRC*W-1:0] src,
  output logic [W-1:0]      y
);
  logic [W-1:0] term [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_term
    assign term[i] = en[i] ? src[i*W +: W] : '0;
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < NSRC; i++) y = y | term[i];
  end
endmodule

// File: rtl/nib_ram_wr.sv
module nib_ram_wr
  import nib_uop_pkg::*;
#(
  parameter int W = 4
) (
  input  ctl_t         ctl,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] key,
  input  logic [W-1:0] ram,
  output logic         we,
  output logic [W-1:0] wdata
);
  logic [W-1:0] mask;

  assign mask = W'(1) << ctl.bit_sel;

  always_comb begin
    we    = 1'b0;
    wdata = ram;
    if (ctl.micro) begin
      we = ctl.uop.wr_acc | ctl.uop.wr_key;
      if (ctl.uop.wr_key)      wdata = key;
      else if (ctl.uop.wr_acc) wdata = acc;
    end else begin
      we = ctl.set_bit | ctl.clr_bit;
      if (ctl.clr_bit)      wdata = ram & ~mask;
      else if (ctl.set_bit) wdata = ram | mask;
    end
  end
endmodule

// File: rtl/nib_uop_alu.sv
module nib_uop_alu
  import nib_uop_pkg::*;
#(
  parameter int W  = 4,
  parameter int XW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_micro,
  input  logic [17:0]       uop,
  input  logic              set_bit,
  input  logic              clr_bit,
  input  logic [1:0]        bit_sel,
  input  logic [W-1:0]      acc_in,
  input  logic [W-1:0]      y_in,
  input  logic [XW-1:0]     x_in,
  input  logic [W-1:0]      ram_rdata,
  input  logic [W-1:0]      key_in,
  input  logic [W-1:0]      dam_in,
  output logic [1:0]        phase,
  output logic [XW+W-1:0]   ram_addr,
  output logic              ram_we,
  output logic [W-1:0]      ram_wdata,
  output logic [W-1:0]      wb_data,
  output logic              acc_we,
  output logic              y_we,
  output logic              stl_we,
  output logic              status
);
  localparam int NSRC = 5;
  localparam int SW   = W + 1;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phase_e ph;
  nib_phase_seq u_seq (.clk(clk), .rst_n(rst_core_n), .phase(ph));
  assign phase = ph;

  // Snapshot registers (slot 0)
  ctl_t         ctl_q, ctl_d;
  logic [W-1:0] acc_q, y_q, ram_q, key_q, dam_q;
  logic [XW-1:0] x_q;
  logic         snap_en;

  assign snap_en = (ph == PH_LATCH);
  always_comb begin
    ctl_d.micro   = is_micro;
    ctl_d.uop     = uop_t'(uop);
    ctl_d.set_bit = set_bit;
    ctl_d.clr_bit = clr_bit;
    ctl_d.bit_sel = bit_sel;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctl_q <= '0;
      acc_q <= '0; y_q <= '0; x_q <= '0;
      ram_q <= '0; key_q <= '0; dam_q <= '0;
    end else if (snap_en) begin
      ctl_q <= ctl_d;
      acc_q <= acc_in; y_q <= y_in; x_q <= x_in;
      ram_q <= ram_rdata; key_q <= key_in; dam_q <= dam_in;
    end
  end

  // Operand selection
  logic [W-1:0] n_sel_v, p_sel_v;
  nib_or_sel #(.W(W), .NSRC(NSRC)) u_nsel (
    .en (ctl_q.uop.n_sel),
    .src({ram_q, key_q, ~acc_q, acc_q, {W{1'b1}}}),
    .y  (n_sel_v)
  );
  nib_or_sel #(.W(W), .NSRC(NSRC)) u_psel (
    .en (ctl_q.uop.p_sel),
    .src({ram_q, key_q, ~dam_q, dam_q, y_q}),
    .y  (p_sel_v)
  );

  logic         ram_we_v;
  logic [W-1:0] ram_wdata_v;
  nib_ram_wr #(.W(W)) u_ramwr (
    .ctl(ctl_q), .acc(acc_q), .key(key_q), .ram(ram_q),
    .we(ram_we_v), .wdata(ram_wdata_v)
  );

  // Datapath next state
  logic [W-1:0]  n_q, n_d, p_q, p_d;
  logic          cin_q, cin_d;
  logic [SW-1:0] sum_q, sum_d, sum_v;
  logic          st_q, st_d;
  logic          rwe_q, rwe_d;
  logic [W-1:0]  rwd_q, rwd_d;
  logic          awe_q, awe_d, ywe_q, ywe_d, swe_q, swe_d;

  assign sum_v = SW'(p_q) + SW'(n_q) + SW'(cin_q);

  always_comb begin
    n_d = n_q; p_d = p_q; cin_d = cin_q;
    sum_d = sum_q; st_d = st_q;
    rwe_d = 1'b0; rwd_d = rwd_q;
    awe_d = 1'b0; ywe_d = 1'b0; swe_d = 1'b0;
    unique case (ph)
      PH_LATCH: begin
        n_d = '0; p_d = '0; cin_d = 1'b0; st_d = 1'b1;
      end
      PH_SELECT: begin
        if (ctl_q.micro) begin
          n_d   = n_sel_v;
          p_d   = p_sel_v;
          cin_d = ctl_q.uop.cin;
        end
      end
      PH_ADD: begin
        sum_d = sum_v;
        if (ctl_q.micro) begin
          if (ctl_q.uop.tst_ne && (n_q == p_q)) st_d = 1'b0;
          if (ctl_q.uop.tst_carry)              st_d = sum_v[W];
        end
        rwe_d = ram_we_v;
        rwd_d = ram_wdata_v;
      end
      default: begin
        awe_d = ctl_q.micro & ctl_q.uop.ld_acc;
        ywe_d = ctl_q.micro & ctl_q.uop.ld_y;
        swe_d = ctl_q.micro & ctl_q.uop.ld_stl;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      n_q <= '0; p_q <= '0; cin_q <= 1'b0;
      sum_q <= '0; st_q <= 1'b1;
      rwe_q <= 1'b0; rwd_q <= '0;
      awe_q <= 1'b0; ywe_q <= 1'b0; swe_q <= 1'b0;
    end else begin
      n_q <= n_d; p_q <= p_d; cin_q <= cin_d;
      sum_q <= sum_d; st_q <= st_d;
      rwe_q <= rwe_d; rwd_q <= rwd_d;
      awe_q <= awe_d; ywe_q <= ywe_d; swe_q <= swe_d;
    end
  end

  assign ram_addr  = {x_q, y_q};
  assign ram_we    = rwe_q;
  assign ram_wdata = rwd_q;
  assign wb_data   = sum_q[W-1:0];
  assign acc_we    = awe_q;
  assign y_we      = ywe_q;
  assign stl_we    = swe_q;
  assign status    = st_q;

  // R6: carry test sets status from the sum carry
  p_carry_status_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph == PH_STORE && ctl_q.micro && ctl_q.uop.tst_carry) |-> (st_q == sum_q[W]));
  // R6: equal operands under the not-equal test clear status
  p_ne_clear_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph == PH_STORE && ctl_q.micro && ctl_q.uop.tst_ne && !ctl_q.uop.tst_carry
     && n_q == p_q) |-> !st_q);
  // R7: status is 1 while operands are being formed
  p_status_default_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph == PH_SELECT) |-> st_q);
  // R8: RAM write only in the store slot
  p_ram_slot_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    rwe_q |-> (ph == PH_STORE));
  // R10: write-back strobes only in slot 0
  p_wb_slot_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (awe_q | ywe_q | swe_q) |-> (ph == PH_LATCH));
  // R11: fixed-path instructions raise no write-back strobe
  p_fixed_quiet_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph == PH_LATCH && !ctl_q.micro) |-> !(awe_q | ywe_q | swe_q));
endmodule

// File: tb/nib_uop_alu_test.sv
module nib_uop_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_micro, set_bit, clr_bit;
  logic [17:0] uop;
  logic [1:0]  bit_sel;
  logic [3:0]  acc_in, y_in, ram_rdata, key_in, dam_in;
  logic [1:0]  x_in;
  logic [1:0]  phase;
  logic [5:0]  ram_addr;
  logic        ram_we, acc_we, y_we, stl_we, status;
  logic [3:0]  ram_wdata, wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  nib_uop_alu uut (
    .clk(clk), .rst_n(rst_n), .is_micro(is_micro), .uop(uop),
    .set_bit(set_bit), .clr_bit(clr_bit), .bit_sel(bit_sel),
    .acc_in(acc_in), .y_in(y_in), .x_in(x_in), .ram_rdata(ram_rdata),
    .key_in(key_in), .dam_in(dam_in), .phase(phase), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .wb_data(wb_data),
    .acc_we(acc_we), .y_we(y_we), .stl_we(stl_we), .status(status)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] wd;
    logic       st;
    logic       awe, ywe, swe;
    logic [3:0] wb;
  } exp_t;

  function automatic exp_t model();
    exp_t e;
    logic [3:0] n, p, m;
    logic [4:0] s;
    n = 4'h0; p = 4'h0;
    e = '0;
    if (is_micro) begin
      if (uop[0]) n |= 4'hF;
      if (uop[1]) n |= acc_in;
      if (uop[2]) n |= ~acc_in;
      if (uop[3]) n |= key_in;
      if (uop[4]) n |= ram_rdata;
      if (uop[5]) p |= y_in;
      if (uop[6]) p |= dam_in;
      if (uop[7]) p |= ~dam_in;
      if (uop[8]) p |= key_in;
      if (uop[9]) p |= ram_rdata;
    end
    s = {1'b0, p} + {1'b0, n} + {4'b0, (is_micro & uop[10])};
    e.st = 1'b1;
    if (is_micro && uop[11] && n == p) e.st = 1'b0;
    if (is_micro && uop[12]) e.st = s[4];
    e.wb = s[3:0];
    m = 4'b0001 << bit_sel;
    if (is_micro) begin
      e.we = uop[13] | uop[14];
      e.wd = uop[14] ? key_in : acc_in;
      e.awe = uop[15]; e.ywe = uop[16]; e.swe = uop[17];
    end else begin
      e.we = set_bit | clr_bit;
      e.wd = clr_bit ? (ram_rdata & ~m) : (ram_rdata | m);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called just after a negedge with phase 0; returns at the next slot-0 negedge.
  task automatic run_instr(input string tw, input string ts);
    exp_t e;
    string tr;
    logic [5:0] ea;
    e  = model();
    ea = {x_in, y_in};
    tr = is_micro ? "R8" : "R9";
    chk("R1", "phase at latch", phase, 0);
    repeat (3) @(negedge clk);
    chk("R1", "phase at store", phase, 3);
    chk(tr, "ram_we", ram_we, e.we);
    if (e.we) chk(tr, "ram_wdata", ram_wdata, e.wd);
    chk("R8", "ram_addr", ram_addr, ea);
    chk(tw, "status", status, e.st);
    @(negedge clk);
    chk(ts, "acc_we", acc_we, e.awe);
    chk(ts, "y_we", y_we, e.ywe);
    chk(ts, "stl_we", stl_we, e.swe);
    chk(tw, "wb_data", wb_data, e.wb);
    chk(tw, "status held", status, e.st);
    chk("R8", "ram_we after slot", ram_we, 0);
  endtask

  task automatic setup(input logic mi, input logic [17:0] u, input logic sb, input logic cb,
                       input logic [1:0] bs, input logic [3:0] a, input logic [3:0] y,
                       input logic [3:0] r, input logic [3:0] k, input logic [3:0] d);
    is_micro = mi; uop = u; set_bit = sb; clr_bit = cb; bit_sel = bs;
    acc_in = a; y_in = y; ram_rdata = r; key_in = k; dam_in = d;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    x_in = 2'd2;
    setup(1'b0, 18'h0, 1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
    repeat (4) @(negedge clk);
    chk("R2", "phase in reset", phase, 0);
    chk("R2", "status in reset", status, 1);
    chk("R2", "ram_we in reset", ram_we, 0);
    chk("R2", "strobes in reset", {acc_we, y_we, stl_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    while (phase != 2'd0) @(negedge clk);

    // R3: N sources ORed
    setup(1'b1, 18'h0000A | (18'h1 << 15), 1'b0, 1'b0, 2'd0, 4'h5, 4'h0, 4'h0, 4'h2, 4'h0);
    run_instr("R3", "R10");
    setup(1'b1, 18'h00004 | (18'h1 << 15), 1'b0, 1'b0, 2'd0, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0);
    run_instr("R3", "R10");
    // R4: P sources ORed
    setup(1'b1, 18'h00060 | (18'h1 << 16), 1'b0, 1'b0, 2'd0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h1);
    run_instr("R4", "R10");
    setup(1'b1, 18'h00080 | (18'h1 << 16), 1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1);
    run_instr("R4", "R10");
    // R5: 15 + 15 + 1 wraps with carry
    setup(1'b1, 18'h00421 | (18'h1 << 12) | (18'h1 << 17), 1'b0, 1'b0, 2'd0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0);
    run_instr("R5", "R10");
    // R6: equal operands with not-equal test; unequal; both tests
    setup(1'b1, 18'h00822, 1'b0, 1'b0, 2'd0, 4'h3, 4'h3, 4'h0, 4'h0, 4'h0);
    run_instr("R6", "R10");
    setup(1'b1, 18'h00822, 1'b0, 1'b0, 2'd0, 4'h3, 4'h4, 4'h0, 4'h0, 4'h0);
    run_instr("R6", "R10");
    setup(1'b1, 18'h01822, 1'b0, 1'b0, 2'd0, 4'h9, 4'h9, 4'h0, 4'h0, 4'h0);
    run_instr("R6", "R10");
    // R7: no test bits, sum without carry
    setup(1'b1, 18'h00022 | (18'h1 << 17), 1'b0, 1'b0, 2'd0, 4'h1, 4'h2, 4'h0, 4'h0, 4'h0);
    run_instr("R7", "R10");
    // R8: store acc, then both writes (key wins)
    x_in = 2'd3;
    setup(1'b1, 18'h1 << 13, 1'b0, 1'b0, 2'd0, 4'hA, 4'h6, 4'h0, 4'h5, 4'h0);
    run_instr("R8", "R10");
    setup(1'b1, 18'h3 << 13, 1'b0, 1'b0, 2'd0, 4'hA, 4'h6, 4'h0, 4'h5, 4'h0);
    run_instr("R8", "R10");
    // R9: set bit 2 of 0, clear bit 0 of F, both (clear wins)
    setup(1'b0, 18'h0, 1'b1, 1'b0, 2'd2, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0);
    run_instr("R9", "R11");
    setup(1'b0, 18'h0, 1'b0, 1'b1, 2'd0, 4'h0, 4'h1, 4'hF, 4'h0, 4'h0);
    run_instr("R9", "R11");
    setup(1'b0, 18'h0, 1'b1, 1'b1, 2'd3, 4'h0, 4'h1, 4'h9, 4'h0, 4'h0);
    run_instr("R9", "R11");
    // R11: micro bits ignored on fixed path; fixed bits ignored on micro path
    setup(1'b0, 18'h3FFFF, 1'b0, 1'b0, 2'd0, 4'h7, 4'h7, 4'h7, 4'h7, 4'h7);
    run_instr("R11", "R11");
    setup(1'b1, 18'h0, 1'b1, 1'b1, 2'd1, 4'h7, 4'h7, 4'h0, 4'h7, 4'h7);
    run_instr("R11", "R11");

    // Random mix checked against the model (R5 data, R10 strobes)
    for (int i = 0; i < 400; i++) begin
      x_in = 2'($urandom);
      setup(($urandom % 10) < 7, 18'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
            4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
      run_instr("R5", "R10");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule